// File: doc/BRIEF.md
# Prioritized Interrupt Vector Sequencer

This block sits beside a small processor core and decides when the core leaves its program to serve an interrupt. Four request lines arrive, already masked by their own enables: external line 0, external line 1, port-low and timer overflow. At an instruction boundary, or while the core sleeps, the block takes the most urgent pending request if the global enable is set and no post-return hold is active. It then owns the core for a fixed number of cycles. During that time it clears the global enable, writes the current program counter to the stack, loads the vector address and acknowledges the chosen source.

A return request runs the matching exit sequence. The block reads the saved program counter back from the stack, loads it, and sets the global enable again. It also arms a hold, so that one instruction of the interrupted program completes before any new request is accepted. Software may set the enable inside a handler, which allows nesting to any depth. The stack memory and the datapath lie outside the block and talk to it through simple strobe ports.

Top module: `irq_vec_seq`

## Requirements
- R1: A request is accepted only on a cycle where the sequencer is idle, `gie_o` is 1, at least one `irq_i` bit is 1, the post-return hold is inactive, `ret_i` is 0 and either `insn_done_i` or `sleep_i` is 1. While a multi-cycle instruction runs (`insn_done_i` low, not sleeping), nothing is accepted.
- R2: Priority is fixed, and the lowest set `irq_i` bit wins. The bits are: bit 0 external line 0, bit 1 external line 1, bit 2 port-low, bit 3 timer overflow. The 10-bit vector address is 1 + bit index, giving 1, 2, 3 and 4.
- R3: An entry from the awake state keeps `busy_o` high for 4 cycles after the accepting edge. The push happens in the 1st cycle and the `pc_load_o` vector pulse in the 4th.
- R4: An entry accepted while `sleep_i` is 1 takes 4 extra cycles. The push moves to the 5th cycle and the vector pulse to the 8th.
- R5: `gie_o` becomes 0 on the accepting edge and stays 0 through the entry.
- R6: Each entry gives exactly one `stk_we_o` pulse. `stk_wdata_o` carries the `pc_i` value sampled on the accepting edge.
- R7: `ack_o` is one-hot for exactly one cycle, in the same cycle as the vector pulse. Its bit position is the serviced source's `irq_i` bit. At all other times it is zero.
- R8: A return (`ret_i` while idle) pulses `stk_re_o` in the 1st cycle. It loads the word read back (valid the cycle after `stk_re_o`) with `pc_load_o` in the 4th cycle, with `ack_o` zero. From the 5th cycle `gie_o` is 1.
- R9: After a return, the first `insn_done_i` is never an accepting cycle. The next one may be.
- R10: Requests present while `gie_o` is 0 cause no activity. After `gie_o` is set they are taken one per entry in priority order.
- R11: A handler that sets the enable can be interrupted again. Successive returns restore the saved program counters in last-in, first-out order.
- R12: While idle, `gie_set_i` makes `gie_o` 1 and `gie_clr_i` makes it 0, both from the next cycle.
- R13: After reset `gie_o`, `busy_o`, `stk_we_o`, `stk_re_o`, `pc_load_o` and `ack_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 4 | Masked requests, bit 0 highest priority |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| sleep_i | input | 1 | Core is sleeping |
| ret_i | input | 1 | Return-from-interrupt instruction completes this cycle |
| gie_set_i | input | 1 | Software sets the global enable |
| gie_clr_i | input | 1 | Software clears the global enable |
| pc_i | input | 10 | Program counter to save |
| stk_rdata_i | input | 10 | Word read from the stack, valid the cycle after a read strobe |
| stk_we_o | output | 1 | Stack push strobe |
| stk_wdata_o | output | 10 | Word to push |
| stk_re_o | output | 1 | Stack pop strobe |
| pc_load_o | output | 1 | Load `pc_load_addr_o` into the program counter |
| pc_load_addr_o | output | 10 | Vector address or restored program counter |
| ack_o | output | 4 | One-hot clear for the serviced source |
| gie_o | output | 1 | Global interrupt enable |
| busy_o | output | 1 | Sequencer owns the core |

## Verification
The bench keeps the default parameters: four sources, a 10-bit program counter, and 4-cycle entry, wake and return windows. With these values every vector address and every priority tie among the four sources can be listed in one short table. A saved program counter of 3FF reaches the top of the stored width. The short windows let the bench count the exact cycle of each push, pop and load for both awake and sleeping entry. A bench-side stack model makes two-level nesting and its last-in, first-out unwinding visible at the ports.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_WAKE   = 2'd1,
    SEQ_ENTER  = 2'd2,
    SEQ_RETURN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign seen[g+1] = seen[g] | req_i[g];
  end

  assign any_o = seen[N_SRC];

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic accept_i,
  input  logic ret_done_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic insn_done_i,
  output logic gie_o,
  output logic hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_o  <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      if (accept_i)                 gie_o <= 1'b0;
      else if (ret_done_i)          gie_o <= 1'b1;
      else if (idle_i && sw_clr_i)  gie_o <= 1'b0;
      else if (idle_i && sw_set_i)  gie_o <= 1'b1;

      // one main-program instruction must retire after a return
      if (ret_done_i)                  hold_o <= 1'b1;
      else if (idle_i && insn_done_i)  hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_vec_pkg::*;
#(
  parameter int PC_W      = 10,
  parameter int ENTRY_CYC = 4,
  parameter int WAKE_CYC  = 4,
  parameter int RET_CYC   = 4,
  localparam int MAX_CYC  = (ENTRY_CYC > WAKE_CYC) ?
                            ((ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC) :
                            ((WAKE_CYC > RET_CYC) ? WAKE_CYC : RET_CYC),
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_entry_i,
  input  logic            wake_i,
  input  logic            start_ret_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] stk_rdata_i,
  output logic            idle_o,
  output logic            stk_we_o,
  output logic [PC_W-1:0] stk_wdata_o,
  output logic            stk_re_o,
  output logic            load_vec_o,
  output logic            load_ret_o,
  output logic [PC_W-1:0] pop_pc_o
);
  localparam logic [CNT_W-1:0] ENT_LAST  = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] RET_LAST  = CNT_W'(RET_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pc_q    <= '0;
      pop_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          cnt_q <= '0;
          if (start_entry_i) begin
            pc_q    <= pc_i;
            state_q <= wake_i ? SEQ_WAKE : SEQ_ENTER;
          end else if (start_ret_i) begin
            state_q <= SEQ_RETURN;
          end
        end
        SEQ_WAKE: begin
          if (cnt_q == WAKE_LAST) begin
            cnt_q   <= '0;
            state_q <= SEQ_ENTER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_ENTER: begin
          if (cnt_q == ENT_LAST) begin
            cnt_q   <= '0;
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_RETURN: begin
          // stack answers one cycle after the read strobe
          if (cnt_q == CNT_W'(1)) pop_q <= stk_rdata_i;
          if (cnt_q == RET_LAST) begin
            cnt_q   <= '0;
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign idle_o      = (state_q == SEQ_IDLE);
  assign stk_we_o    = (state_q == SEQ_ENTER)  && (cnt_q == '0);
  assign stk_re_o    = (state_q == SEQ_RETURN) && (cnt_q == '0);
  assign load_vec_o  = (state_q == SEQ_ENTER)  && (cnt_q == ENT_LAST);
  assign load_ret_o  = (state_q == SEQ_RETURN) && (cnt_q == RET_LAST);
  assign stk_wdata_o = pc_q;
  assign pop_pc_o    = pop_q;
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq #(
  parameter int N_SRC     = 4,
  parameter int PC_W      = 10,
  parameter int VEC_BASE  = 1,
  parameter int ENTRY_CYC = 4,
  parameter int WAKE_CYC  = 4,
  parameter int RET_CYC   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             insn_done_i,
  input  logic             sleep_i,
  input  logic             ret_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  stk_rdata_i,
  output logic             stk_we_o,
  output logic [PC_W-1:0]  stk_wdata_o,
  output logic             stk_re_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_load_addr_o,
  output logic [N_SRC-1:0] ack_o,
  output logic             gie_o,
  output logic             busy_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             any_req;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] sel_q;
  logic             idle, hold, accept, start_ret;
  logic             load_vec, load_ret;
  logic [PC_W-1:0]  pop_pc;

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i (irq_i),
    .any_o (any_req),
    .idx_o (win_idx)
  );

  assign accept    = idle && gie_o && any_req && !hold && !ret_i &&
                     (insn_done_i || sleep_i);
  assign start_ret = idle && ret_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (accept) sel_q <= win_idx;
  end

  irq_gie_ctrl u_gie (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (idle),
    .accept_i    (accept),
    .ret_done_i  (load_ret),
    .sw_set_i    (gie_set_i),
    .sw_clr_i    (gie_clr_i),
    .insn_done_i (insn_done_i),
    .gie_o       (gie_o),
    .hold_o      (hold)
  );

  irq_seq_fsm #(
    .PC_W      (PC_W),
    .ENTRY_CYC (ENTRY_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .RET_CYC   (RET_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_entry_i (accept),
    .wake_i        (sleep_i),
    .start_ret_i   (start_ret),
    .pc_i          (pc_i),
    .stk_rdata_i   (stk_rdata_i),
    .idle_o        (idle),
    .stk_we_o      (stk_we_o),
    .stk_wdata_o   (stk_wdata_o),
    .stk_re_o      (stk_re_o),
    .load_vec_o    (load_vec),
    .load_ret_o    (load_ret),
    .pop_pc_o      (pop_pc)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    assign ack_o[g] = load_vec && (sel_q == IDX_W'(g));
  end

  assign pc_load_o      = load_vec || load_ret;
  assign pc_load_addr_o = load_vec ? (PC_W'(VEC_BASE) + PC_W'(sel_q)) : pop_pc;
  assign busy_o         = !idle;
endmodule

// File: rtl/irq_vec_seq_chk.sv
module irq_vec_seq_chk #(
  parameter int N_SRC     = 4,
  parameter int ENTRY_CYC = 4,
  localparam int SC_W     = $clog2(ENTRY_CYC + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] irq_i,
  input logic             insn_done_i,
  input logic             sleep_i,
  input logic             stk_we_o,
  input logic             stk_re_o,
  input logic             pc_load_o,
  input logic [N_SRC-1:0] ack_o,
  input logic             gie_o,
  input logic             busy_o
);
  logic [SC_W-1:0] since_push_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_push_q <= '0;
    else if (stk_we_o)                    since_push_q <= SC_W'(1);
    else if (since_push_q != '1)          since_push_q <= since_push_q + 1'b1;
  end

  assert_accept_cond_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o) && !stk_re_o) |->
      $past(gie_o && |irq_i && (insn_done_i || sleep_i)));

  assert_push_to_vec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (since_push_q == SC_W'(ENTRY_CYC - 1)));

  assert_gie_low_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o |-> !gie_o);

  assert_ack_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  assert_ack_with_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (pc_load_o && busy_o));

  assert_ack_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |=> (ack_o == '0));

  assert_ret_sets_gie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o && (ack_o == '0)) |=> gie_o);
endmodule

bind irq_vec_seq irq_vec_seq_chk #(.N_SRC(N_SRC), .ENTRY_CYC(ENTRY_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .insn_done_i (insn_done_i),
  .sleep_i     (sleep_i),
  .stk_we_o    (stk_we_o),
  .stk_re_o    (stk_re_o),
  .pc_load_o   (pc_load_o),
  .ack_o       (ack_o),
  .gie_o       (gie_o),
  .busy_o      (busy_o)
);

// File: tb/tb_irq_vec_seq.sv
module tb_irq_vec_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] irq_i = '0;
  logic       insn_done_i = 1'b0, sleep_i = 1'b0, ret_i = 1'b0;
  logic       gie_set_i = 1'b0, gie_clr_i = 1'b0;
  logic [9:0] pc_i = '0, stk_rdata_i = '0;
  logic       stk_we_o, stk_re_o, pc_load_o, gie_o, busy_o;
  logic [9:0] stk_wdata_o, pc_load_addr_o;
  logic [3:0] ack_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_vec_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .insn_done_i(insn_done_i),
    .sleep_i(sleep_i), .ret_i(ret_i), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
    .pc_i(pc_i), .stk_rdata_i(stk_rdata_i), .stk_we_o(stk_we_o),
    .stk_wdata_o(stk_wdata_o), .stk_re_o(stk_re_o), .pc_load_o(pc_load_o),
    .pc_load_addr_o(pc_load_addr_o), .ack_o(ack_o), .gie_o(gie_o), .busy_o(busy_o)
  );

  // stack memory model
  logic [9:0] stk_mem [0:15];
  int sp = 0;
  always @(posedge clk_i) begin
    if (stk_we_o) begin
      stk_mem[sp[3:0]] <= stk_wdata_o;
      sp <= sp + 1;
    end else if (stk_re_o) begin
      stk_rdata_i <= stk_mem[(sp - 1) & 15];
      sp <= sp - 1;
    end
  end

  // {irq, sleep, pc, exp_addr, exp_ack}
  localparam logic [28:0] VECS [0:9] = '{
    {4'b0001, 1'b0, 10'h123, 10'd1, 4'b0001},
    {4'b0010, 1'b0, 10'h0a5, 10'd2, 4'b0010},
    {4'b0100, 1'b0, 10'h3ff, 10'd3, 4'b0100},
    {4'b1000, 1'b0, 10'h000, 10'd4, 4'b1000},
    {4'b1111, 1'b0, 10'h2aa, 10'd1, 4'b0001},
    {4'b1110, 1'b0, 10'h155, 10'd2, 4'b0010},
    {4'b1100, 1'b0, 10'h0f0, 10'd3, 4'b0100},
    {4'b1010, 1'b1, 10'h301, 10'd2, 4'b0010},
    {4'b1000, 1'b1, 10'h07e, 10'd4, 4'b1000},
    {4'b0110, 1'b1, 10'h1c3, 10'd2, 4'b0010}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic pulse_gie(input bit set);
    gie_set_i = set; gie_clr_i = !set;
    tick();
    gie_set_i = 1'b0; gie_clr_i = 1'b0;
  endtask

  // R3 R4 R5 R6 R7 R2: one entry, counted cycle by cycle after the accepting edge
  task automatic do_entry(input logic [3:0] irq, input bit slp, input logic [9:0] pc,
                          input logic [9:0] exp_addr, input logic [3:0] exp_ack);
    int push_k = 0, load_k = 0, n_push = 0;
    logic [9:0] push_d = '0, load_a = '0;
    logic [3:0] ack_seen = '0;
    logic gie_k1 = 1'b1;
    irq_i = irq; pc_i = pc;
    if (slp) sleep_i = 1'b1; else insn_done_i = 1'b1;
    tick();
    insn_done_i = 1'b0; sleep_i = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (k == 1) gie_k1 = gie_o;
      if (stk_we_o) begin n_push++; push_k = k; push_d = stk_wdata_o; end
      if (pc_load_o && load_k == 0) begin
        load_k = k; load_a = pc_load_addr_o; ack_seen = ack_o;
        irq_i = irq_i & ~ack_o;
      end
      tick();
    end
    chk(gie_k1 == 1'b0, "R5 gie clear on entry", 32'(gie_k1), 0);
    chk(push_k == (slp ? 5 : 1), slp ? "R4 push cycle" : "R3 push cycle", push_k, slp ? 5 : 1);
    chk(load_k == (slp ? 8 : 4), slp ? "R4 vector cycle" : "R3 vector cycle", load_k, slp ? 8 : 4);
    chk(n_push == 1 && push_d == pc, "R6 pushed pc", 32'(push_d), 32'(pc));
    chk(load_a == exp_addr, "R2 vector address", 32'(load_a), 32'(exp_addr));
    chk(ack_seen == exp_ack, "R7 ack bit", 32'(ack_seen), 32'(exp_ack));
    chk(busy_o == 1'b0 && gie_o == 1'b0, "R5 idle after entry, gie still clear", 32'({busy_o, gie_o}), 0);
  endtask

  // R8: return pops and restores
  task automatic do_ret(input logic [9:0] exp_pc);
    int re_k = 0, load_k = 0;
    logic [9:0] load_a = '0;
    logic [3:0] ack_seen = '0;
    logic gie_k5 = 1'b0;
    ret_i = 1'b1;
    tick();
    ret_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (stk_re_o && re_k == 0) re_k = k;
      if (pc_load_o && load_k == 0) begin load_k = k; load_a = pc_load_addr_o; ack_seen = ack_o; end
      if (k == 5) gie_k5 = gie_o;
      tick();
    end
    chk(re_k == 1 && load_k == 4, "R8 pop/load cycles", 32'({re_k[7:0], load_k[7:0]}), 32'h0104);
    chk(load_a == exp_pc && ack_seen == 4'b0, "R8 restored pc", 32'(load_a), 32'(exp_pc));
    chk(gie_k5 == 1'b1, "R8 gie set after return", 32'(gie_k5), 1);
  endtask

  task automatic retire_one();
    insn_done_i = 1'b1;
    tick();
    insn_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    // R13
    chk({gie_o, busy_o, stk_we_o, stk_re_o, pc_load_o, ack_o} == '0, "R13 reset state",
        32'({gie_o, busy_o, stk_we_o, stk_re_o, pc_load_o, ack_o}), 0);

    // R10: pending with enable clear does nothing
    irq_i = 4'b1010;
    for (int i = 0; i < 3; i++) retire_one();
    chk(busy_o == 1'b0 && stk_we_o == 1'b0, "R10 no entry while gie clear", 32'(busy_o), 0);

    // R12
    pulse_gie(1'b1);
    chk(gie_o == 1'b1, "R12 software set", 32'(gie_o), 1);
    pulse_gie(1'b0);
    chk(gie_o == 1'b0, "R12 software clear", 32'(gie_o), 0);
    pulse_gie(1'b1);

    // R10: pending requests served in priority order once enabled
    do_entry(4'b1010, 1'b0, 10'h011, 10'd2, 4'b0010);
    do_ret(10'h011);
    retire_one();
    do_entry(irq_i, 1'b0, 10'h012, 10'd4, 4'b1000);
    do_ret(10'h012);
    retire_one();

    // vector table
    for (int v = 0; v < 10; v++) begin
      logic [28:0] e;
      e = VECS[v];
      pulse_gie(1'b1);
      do_entry(e[28:25], e[24], e[23:14], e[13:4], e[3:0]);
      irq_i = '0;
      do_ret(e[23:14]);
      retire_one();
    end

    // R1: multi-cycle instruction blocks acceptance
    irq_i = 4'b0100;
    for (int i = 0; i < 4; i++) tick();
    chk(busy_o == 1'b0, "R1 held during multi-cycle instruction", 32'(busy_o), 0);
    do_entry(4'b0100, 1'b0, 10'h200, 10'd3, 4'b0100);

    // R11: nested entry inside handler, then LIFO unwind
    pulse_gie(1'b1);
    do_entry(4'b1000, 1'b0, 10'h2f0, 10'd4, 4'b1000);
    irq_i = '0;
    do_ret(10'h2f0);
    retire_one();
    do_ret(10'h200);

    // R9: first instruction after return never accepts
    irq_i = 4'b0001;
    retire_one();
    chk(busy_o == 1'b0, "R9 one instruction runs after return", 32'(busy_o), 0);
    do_entry(4'b0001, 1'b0, 10'h0aa, 10'd1, 4'b0001);
    irq_i = '0;
    do_ret(10'h0aa);
    retire_one();

    // R1: ret_i wins over a pending request on the same boundary
    irq_i = 4'b0010;
    ret_i = 1'b1; insn_done_i = 1'b1;
    tick();
    ret_i = 1'b0; insn_done_i = 1'b0;
    chk(stk_re_o == 1'b1 && stk_we_o == 1'b0, "R1 return taken instead of entry",
        32'({stk_re_o, stk_we_o}), 2);
    for (int i = 0; i < 5; i++) tick();
    irq_i = '0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule